// File: doc/BRIEF.md
# Region Address Remap Table

This block turns addresses from a 32 MB local memory-mapped window into full 64-bit bus addresses. The local window is cut into thirty-two 1 MB pages. Each page has its own 64-bit base held in a software-loaded table. The top five bits of a 25-bit local address pick a table entry. The low twenty bits pass through unchanged as the offset inside the page.

The block holds two independent tables, one for the read-traffic path and one for the write-traffic path, each with its own translation port. Both tables sit behind one register slave. Software loads and reads back the bases through it, one 64-bit word per entry. Each translation takes one registered cycle. Its valid flag travels alongside the address.

Top module: `region_remap`

## Requirements
- R1: After reset every entry of both tables is zero, both translation outputs have valid low and address zero, and the register read port has `reg_rvalid` low and `reg_rdata` zero.
- R2: A register write with `reg_addr` in 0x100..0x1FF stores `reg_wdata` into read-path entry `reg_addr[7:3]`. A write in 0x200..0x2FF stores into write-path entry `reg_addr[7:3]`. Bits `reg_addr[2:0]` are ignored.
- R3: A register read returns the addressed entry on `reg_rdata` in the next cycle with `reg_rvalid` high for that one cycle. When no read is requested, `reg_rvalid` is low in the next cycle and `reg_rdata` holds its last value.
- R4: A register read outside both table windows returns zero. A register write outside both windows changes no entry.
- R5: A translation output equals the bits [63:20] of the entry selected by request bits [24:20], joined with request bits [19:0]. The entry's own bits [19:0] play no part.
- R6: Each translation output's valid is the request valid delayed by exactly one cycle.
- R7: While request valid is low, the translation output address keeps its previous value.
- R8: A lookup in the same cycle as a register write to the same entry uses the entry's old value. A lookup one cycle later sees the new value.
- R9: A register read in the same cycle as a register write to the same entry returns the old value.
- R10: The two tables are independent. Writing one table never changes the translation or readback of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| reg_rdata | output | 64 | Register read data |
| rd_req_valid | input | 1 | Read-path lookup request valid |
| rd_req_addr | input | 25 | Read-path local address |
| rd_out_valid | output | 1 | Read-path translated address valid |
| rd_out_addr | output | 64 | Read-path translated address |
| wr_req_valid | input | 1 | Write-path lookup request valid |
| wr_req_addr | input | 25 | Write-path local address |
| wr_out_valid | output | 1 | Write-path translated address valid |
| wr_out_addr | output | 64 | Write-path translated address |

## Verification
Entries are loaded with patterns whose bits differ above and below bit 20. A lookup that passed entry bits into the offset field, or that used the wrong split point, therefore yields a visibly wrong address. Lookups sweep the extreme indices 0 and 31 and all-ones and all-zero offsets, with gaps between requests, which exposes index slicing errors, valid/latency skew and failure to hold. The same index is programmed with different values in the two tables, so that cross-wired table selection is detected. Writes and lookups, and writes and readbacks, are also issued to the same entry in the same cycle, which separates old-value forwarding from new-value bypass. A long randomised phase mixes window and out-of-window register traffic with both lookup streams.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int DEF_LOCAL_AW = 25;
    localparam int DEF_PAGE_W   = 20;
    localparam int DEF_BUS_AW   = 64;
    localparam int DEF_REG_AW   = 16;
    localparam int WORD_LG      = 3;   // 64-bit words: byte offset bits
    localparam int NUM_TBL      = 2;
    localparam int TBL_RD       = 0;
    localparam int TBL_WR       = 1;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
    parameter int DW    = 64,
    parameter int IDX_W = 5,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdata,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [DW-1:0]    lk_data
);
    logic [DW-1:0] mem_d [ENTRIES];
    logic [DW-1:0] mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= mem_d[i];
        end
    end

    // Both read ports see the stored value, so same-cycle writes are not bypassed.
    assign rdata   = mem_q[ridx];
    assign lk_data = mem_q[lk_idx];
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
    parameter int LOCAL_AW = 25,
    parameter int PAGE_W   = 20,
    parameter int BUS_AW   = 64,
    localparam int IDX_W   = LOCAL_AW - PAGE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LOCAL_AW-1:0] req_addr,
    output logic [IDX_W-1:0]    lk_idx,
    input  logic [BUS_AW-1:0]   base_in,
    output logic                out_valid,
    output logic [BUS_AW-1:0]   out_addr
);
    typedef struct packed {
        logic              valid;
        logic [BUS_AW-1:0] addr;
    } xl_st_t;

    xl_st_t st_d, st_q;

    assign lk_idx = req_addr[LOCAL_AW-1:PAGE_W];

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.addr = {base_in[BUS_AW-1:PAGE_W], req_addr[PAGE_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;

    // Page-offset bits of the entry are replaced by the request offset.
    logic unused_base_low;
    assign unused_base_low = ^base_in[PAGE_W-1:0];
endmodule

// File: rtl/remap_regif.sv
module remap_regif
    import remap_pkg::*;
#(
    parameter int                REG_AW  = 16,
    parameter int                DW      = 64,
    parameter int                IDX_W   = 5,
    parameter logic [REG_AW-1:0] RD_BASE = 16'h0100,
    parameter logic [REG_AW-1:0] WR_BASE = 16'h0200,
    localparam int               SPAN_LG = IDX_W + WORD_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_rvalid,
    output logic [DW-1:0]     reg_rdata,
    output logic              tbl_we    [NUM_TBL],
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [DW-1:0]     tbl_wdata,
    input  logic [DW-1:0]     tbl_rdata [NUM_TBL]
);
    localparam logic [REG_AW-1:0] BASES [NUM_TBL] = '{RD_BASE, WR_BASE};

    typedef struct packed {
        logic          rvalid;
        logic [DW-1:0] rdata;
    } rsp_st_t;

    rsp_st_t st_d, st_q;
    logic    hit [NUM_TBL];

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_dec
        assign hit[t]    = (reg_addr[REG_AW-1:SPAN_LG] == BASES[t][REG_AW-1:SPAN_LG]);
        assign tbl_we[t] = reg_wr & hit[t];
    end

    assign tbl_idx   = reg_addr[SPAN_LG-1:WORD_LG];
    assign tbl_wdata = reg_wdata;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = reg_rd;
        if (reg_rd) begin
            st_d.rdata = '0;
            for (int t = 0; t < NUM_TBL; t++) begin
                if (hit[t]) st_d.rdata = tbl_rdata[t];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rvalid = st_q.rvalid;
    assign reg_rdata  = st_q.rdata;

    logic unused_byte_lane;
    assign unused_byte_lane = ^reg_addr[WORD_LG-1:0];
endmodule

// File: rtl/region_remap.sv
module region_remap
    import remap_pkg::*;
#(
    parameter int                LOCAL_AW = DEF_LOCAL_AW,
    parameter int                PAGE_W   = DEF_PAGE_W,
    parameter int                BUS_AW   = DEF_BUS_AW,
    parameter int                REG_AW   = DEF_REG_AW,
    parameter logic [REG_AW-1:0] RD_BASE  = 16'h0100,
    parameter logic [REG_AW-1:0] WR_BASE  = 16'h0200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [BUS_AW-1:0]   reg_wdata,
    output logic                reg_rvalid,
    output logic [BUS_AW-1:0]   reg_rdata,
    input  logic                rd_req_valid,
    input  logic [LOCAL_AW-1:0] rd_req_addr,
    output logic                rd_out_valid,
    output logic [BUS_AW-1:0]   rd_out_addr,
    input  logic                wr_req_valid,
    input  logic [LOCAL_AW-1:0] wr_req_addr,
    output logic                wr_out_valid,
    output logic [BUS_AW-1:0]   wr_out_addr
);
    localparam int IDX_W = LOCAL_AW - PAGE_W;

    logic                tbl_we    [NUM_TBL];
    logic [IDX_W-1:0]    tbl_idx;
    logic [BUS_AW-1:0]   tbl_wdata;
    logic [BUS_AW-1:0]   tbl_rdata [NUM_TBL];

    logic                req_v [NUM_TBL];
    logic [LOCAL_AW-1:0] req_a [NUM_TBL];
    logic                out_v [NUM_TBL];
    logic [BUS_AW-1:0]   out_a [NUM_TBL];

    assign req_v[TBL_RD] = rd_req_valid;
    assign req_a[TBL_RD] = rd_req_addr;
    assign req_v[TBL_WR] = wr_req_valid;
    assign req_a[TBL_WR] = wr_req_addr;

    assign rd_out_valid = out_v[TBL_RD];
    assign rd_out_addr  = out_a[TBL_RD];
    assign wr_out_valid = out_v[TBL_WR];
    assign wr_out_addr  = out_a[TBL_WR];

    remap_regif #(
        .REG_AW (REG_AW),
        .DW     (BUS_AW),
        .IDX_W  (IDX_W),
        .RD_BASE(RD_BASE),
        .WR_BASE(WR_BASE)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rvalid(reg_rvalid),
        .reg_rdata (reg_rdata),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .tbl_rdata (tbl_rdata)
    );

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_path
        logic [IDX_W-1:0]  lk_idx;
        logic [BUS_AW-1:0] lk_data;

        remap_table #(
            .DW   (BUS_AW),
            .IDX_W(IDX_W)
        ) u_table (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (tbl_we[t]),
            .widx   (tbl_idx),
            .wdata  (tbl_wdata),
            .ridx   (tbl_idx),
            .rdata  (tbl_rdata[t]),
            .lk_idx (lk_idx),
            .lk_data(lk_data)
        );

        remap_xlate #(
            .LOCAL_AW(LOCAL_AW),
            .PAGE_W  (PAGE_W),
            .BUS_AW  (BUS_AW)
        ) u_xlate (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_valid(req_v[t]),
            .req_addr (req_a[t]),
            .lk_idx   (lk_idx),
            .base_in  (lk_data),
            .out_valid(out_v[t]),
            .out_addr (out_a[t])
        );
    end
endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
    parameter int                LOCAL_AW = 25,
    parameter int                PAGE_W   = 20,
    parameter int                BUS_AW   = 64,
    parameter int                REG_AW   = 16,
    parameter logic [REG_AW-1:0] RD_BASE  = 16'h0100,
    parameter logic [REG_AW-1:0] WR_BASE  = 16'h0200,
    localparam int               SPAN_LG  = LOCAL_AW - PAGE_W + 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_rd,
    input logic [REG_AW-1:0]   reg_addr,
    input logic                reg_rvalid,
    input logic [BUS_AW-1:0]   reg_rdata,
    input logic                rd_req_valid,
    input logic [LOCAL_AW-1:0] rd_req_addr,
    input logic                rd_out_valid,
    input logic [BUS_AW-1:0]   rd_out_addr,
    input logic                wr_req_valid,
    input logic [LOCAL_AW-1:0] wr_req_addr,
    input logic                wr_out_valid,
    input logic [BUS_AW-1:0]   wr_out_addr
);
    logic outside;
    assign outside = (reg_addr[REG_AW-1:SPAN_LG] != RD_BASE[REG_AW-1:SPAN_LG]) &&
                     (reg_addr[REG_AW-1:SPAN_LG] != WR_BASE[REG_AW-1:SPAN_LG]);

    a_r3_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    a_r3_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    a_r4_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && outside) |=> (reg_rdata == '0));
    a_r5_rd_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> (rd_out_addr[PAGE_W-1:0] == $past(rd_req_addr[PAGE_W-1:0])));
    a_r5_wr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |=> (wr_out_addr[PAGE_W-1:0] == $past(wr_req_addr[PAGE_W-1:0])));
    a_r6_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> rd_out_valid);
    a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_valid |=> !rd_out_valid);
    a_r6_wr_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |=> wr_out_valid);
    a_r6_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_valid |=> !wr_out_valid);
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_valid |=> $stable(rd_out_addr));
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req_valid |=> $stable(wr_out_addr));

    logic unused_chk;
    assign unused_chk = ^{rd_req_addr[LOCAL_AW-1:PAGE_W], wr_req_addr[LOCAL_AW-1:PAGE_W],
                          reg_addr[SPAN_LG-1:0]};
endmodule

bind region_remap remap_checker #(
    .LOCAL_AW(LOCAL_AW),
    .PAGE_W  (PAGE_W),
    .BUS_AW  (BUS_AW),
    .REG_AW  (REG_AW),
    .RD_BASE (RD_BASE),
    .WR_BASE (WR_BASE)
) u_remap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rvalid  (reg_rvalid),
    .reg_rdata   (reg_rdata),
    .rd_req_valid(rd_req_valid),
    .rd_req_addr (rd_req_addr),
    .rd_out_valid(rd_out_valid),
    .rd_out_addr (rd_out_addr),
    .wr_req_valid(wr_req_valid),
    .wr_req_addr (wr_req_addr),
    .wr_out_valid(wr_out_valid),
    .wr_out_addr (wr_out_addr)
);

// File: tb/tb_region_remap.sv
module tb_region_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [63:0] reg_rdata;
    logic        rd_req_valid = 1'b0, wr_req_valid = 1'b0;
    logic [24:0] rd_req_addr = '0, wr_req_addr = '0;
    logic        rd_out_valid, wr_out_valid;
    logic [63:0] rd_out_addr, wr_out_addr;

    always #10 clk = ~clk;   // 50 MHz

    region_remap dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_out_valid(rd_out_valid), .rd_out_addr(rd_out_addr),
        .wr_req_valid(wr_req_valid), .wr_req_addr(wr_req_addr),
        .wr_out_valid(wr_out_valid), .wr_out_addr(wr_out_addr)
    );

    // Behavioural reference
    logic [63:0] ref_rd [32];
    logic [63:0] ref_wr [32];
    logic        e_rd_v, e_wr_v, e_rv;
    logic [63:0] e_rd_a, e_wr_a, e_rdata;

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    done = 1'b0;

    function automatic int which_win(input logic [15:0] a);
        int v = int'(a);
        if (v >= 'h100 && v < 'h200) return 1;
        if (v >= 'h200 && v < 'h300) return 2;
        return 0;
    endfunction

    function automatic int win_idx(input logic [15:0] a);
        return (int'(a) % 256) / 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin ref_rd[i] = '0; ref_wr[i] = '0; end
            e_rd_v = 0; e_wr_v = 0; e_rv = 0;
            e_rd_a = '0; e_wr_a = '0; e_rdata = '0;
        end else begin
            int w, k;
            e_rd_v = rd_req_valid;
            if (rd_req_valid) begin
                k = int'(rd_req_addr) / (1 << 20);
                e_rd_a = (ref_rd[k] & ~64'hFFFFF) | 64'(rd_req_addr % (1 << 20));
            end
            e_wr_v = wr_req_valid;
            if (wr_req_valid) begin
                k = int'(wr_req_addr) / (1 << 20);
                e_wr_a = (ref_wr[k] & ~64'hFFFFF) | 64'(wr_req_addr % (1 << 20));
            end
            e_rv = reg_rd;
            if (reg_rd) begin
                w = which_win(reg_addr);
                k = win_idx(reg_addr);
                e_rdata = (w == 1) ? ref_rd[k] : (w == 2) ? ref_wr[k] : 64'd0;
            end
            if (reg_wr) begin
                w = which_win(reg_addr);
                k = win_idx(reg_addr);
                if (w == 1) ref_rd[k] = reg_wdata;
                if (w == 2) ref_wr[k] = reg_wdata;
            end
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("rd_out_valid", 64'(rd_out_valid), 64'(e_rd_v));
        chk("rd_out_addr",  rd_out_addr, e_rd_a);
        chk("wr_out_valid", 64'(wr_out_valid), 64'(e_wr_v));
        chk("wr_out_addr",  wr_out_addr, e_wr_a);
        chk("reg_rvalid",   64'(reg_rvalid), 64'(e_rv));
        chk("reg_rdata",    reg_rdata, e_rdata);
        reg_wr = 0; reg_rd = 0; rd_req_valid = 0; wr_req_valid = 0;
    endtask

    task automatic regw(input logic [15:0] a, input logic [63:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic regr(input logic [15:0] a);
        reg_rd = 1; reg_addr = a; tick();
    endtask

    task automatic look(input bit rv, input logic [24:0] ra, input bit wv, input logic [24:0] wa);
        rd_req_valid = rv; rd_req_addr = ra; wr_req_valid = wv; wr_req_addr = wa; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports
        tag = "R1";
        tick();
        chk("R1 reset rdata", reg_rdata, 64'd0);
        regr(16'h0100); regr(16'h01F8); regr(16'h0200); regr(16'h02F8);
        look(1, 25'h1FFFFFF, 1, 25'h0000000);

        // R2: programming both tables, low byte bits ignored
        tag = "R2";
        for (int i = 0; i < 32; i++) begin
            regw(16'(16'h0100 + i * 8), {32'hA500_0000 + 32'(i), 32'h5A5A_5A5A ^ 32'(i * 7)});
            regw(16'(16'h0200 + i * 8 + (i % 8)), {32'hC300_0000 + 32'(i), 32'h0F0F_1234 + 32'(i)});
        end
        regw(16'h0105, 64'h1111_2222_3333_4444);
        regr(16'h0100); regr(16'h0207);

        // R3: readback timing and hold
        tag = "R3";
        regr(16'h01F8); tick(); tick(); regr(16'h02F8); regr(16'h0110);

        // R4: out-of-window accesses
        tag = "R4";
        regw(16'h0000, 64'hDEAD_BEEF_DEAD_BEEF);
        regw(16'h0300, 64'hDEAD_BEEF_0000_0001);
        regw(16'h00F8, 64'hDEAD_BEEF_0000_0002);
        regw(16'hFF00, 64'hDEAD_BEEF_0000_0003);
        regr(16'h0000); regr(16'h0300); regr(16'h00F8); regr(16'hF100);
        regr(16'h0100); regr(16'h01F8); regr(16'h0200); regr(16'h02F8);

        // R5: translation, index extremes, offset extremes
        tag = "R5";
        look(1, 25'h0000000, 1, 25'h1FFFFFF);
        look(1, 25'h1FFFFFF, 1, 25'h00FFFFF);
        look(1, 25'h0A12345, 1, 25'h1500001);
        look(1, 25'h1F00000, 1, 25'h0100000);

        // R6: latency with gaps
        tag = "R6";
        look(1, 25'h0300042, 0, 25'h0);
        look(0, 25'h0, 1, 25'h0700099);
        look(1, 25'h0800001, 1, 25'h0800002);

        // R7: hold while idle, inputs moving
        tag = "R7";
        look(0, 25'h1234567, 0, 25'h0ABCDEF);
        look(0, 25'h0000001, 0, 25'h1FFFFFF);
        tick();

        // R8: write and lookup to the same entry in one cycle
        tag = "R8";
        reg_wr = 1; reg_addr = 16'h0100 + 7 * 8; reg_wdata = 64'h7777_0000_FFFF_FFFF;
        rd_req_valid = 1; rd_req_addr = 25'h07ABCDE;
        tick();
        look(1, 25'h07ABCDE, 0, 25'h0);
        reg_wr = 1; reg_addr = 16'h0200 + 31 * 8; reg_wdata = 64'h8888_8888_8000_0000;
        wr_req_valid = 1; wr_req_addr = 25'h1F00010;
        tick();
        look(0, 25'h0, 1, 25'h1F00010);

        // R9: write and readback to the same entry in one cycle
        tag = "R9";
        reg_wr = 1; reg_rd = 1; reg_addr = 16'h0118; reg_wdata = 64'h9999_AAAA_BBBB_CCCC;
        tick();
        regr(16'h0118);

        // R10: same index, different tables
        tag = "R10";
        regw(16'h0200 + 3 * 8, 64'hFEED_0000_0000_0000);
        look(1, 25'h0312345, 1, 25'h0312345);
        regw(16'h0100 + 3 * 8, 64'h0BAD_0000_0000_0000);
        look(1, 25'h0354321, 1, 25'h0354321);
        regr(16'h0218); regr(16'h0118);

        // Mixed traffic across R2..R10
        tag = "R2..mixed";
        for (int n = 0; n < 3000; n++) begin
            int sel = int'($urandom_range(0, 3));
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_rd = ($urandom_range(0, 2) == 0);
            reg_addr = (sel == 0) ? 16'($urandom) : 16'(16'h0100 * (sel == 3 ? 1 : sel) + $urandom_range(0, 255));
            reg_wdata = {$urandom, $urandom};
            rd_req_valid = $urandom_range(0, 1) == 1;
            wr_req_valid = $urandom_range(0, 1) == 1;
            rd_req_addr = 25'($urandom);
            wr_req_addr = 25'($urandom);
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s actual=hung expected=finished", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule